// File: doc/BRIEF.md
# Latch Timing Violation Monitor

This block watches the enable and data inputs of a transparent latch. Both inputs are sampled on a fast reference clock, and the block counts elapsed time in clock cycles. It reports three kinds of timing fault:

- the enable high pulse is too narrow;
- data changed too soon before enable closed (setup);
- data changed too soon after enable moved while enable is low (hold).

Each threshold is a runtime input. A threshold of zero turns its check off.

The checks are driven by events. A check is evaluated only on the cycle when its triggering edge is sampled. On that cycle it compares the elapsed time since an earlier event against its threshold, using the counter value from before that counter restarts. Each fault kind has three outputs:

- a one-cycle pulse;
- a flag that stays set until reset;
- a saturating count.

The inputs are assumed to be synchronous to the clock already.

Top module: `latch_timing_monitor`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, every pulse, sticky flag and count output is zero.
- R2: When enable is sampled falling and a rise was sampled since reset, a width pulse is raised in the following cycle if the number of cycles from the sampled rise to the sampled fall is below `width_min_i`.
- R3: The first sample after reset only loads the edge detectors and is never an edge. A fall of enable with no rise sampled since reset raises no width pulse.
- R4: On a sampled enable fall, a setup pulse is raised in the following cycle if the cycles since the last sampled data change are below `setup_min_i`.
- R5: On a sampled data change while the sampled enable is 0, a hold pulse is raised in the following cycle if the cycles since the last sampled enable change are below `hold_min_i`.
- R6: When data and enable change in the same sampled cycle, the elapsed time used by both the setup and the hold check is zero. An enable fall with a data toggle therefore raises both pulses together when both thresholds are nonzero.
- R7: A threshold of zero suppresses its own pulse, regardless of the input activity.
- R8: The two elapsed-time counters saturate at 2^CNT_W-1 and do not wrap. After a long quiet period, a hold threshold below that maximum is therefore not violated.
- R9: Each sticky flag goes high in the same cycle as the first pulse of its kind and stays high until reset.
- R10: Each violation count increments by one per pulse of its kind and stops at 2^VIOL_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Latch enable, synchronous to clk |
| din_i | input | 1 | Latch data, synchronous to clk |
| width_min_i | input | CNT_W | Minimum enable high time in cycles, 0 disables |
| setup_min_i | input | CNT_W | Minimum data-to-enable-fall cycles, 0 disables |
| hold_min_i | input | CNT_W | Minimum enable-change-to-data cycles, 0 disables |
| width_viol_o | output | 1 | One-cycle pulse for a width fault |
| setup_viol_o | output | 1 | One-cycle pulse for a setup fault |
| hold_viol_o | output | 1 | One-cycle pulse for a hold fault |
| width_sticky_o | output | 1 | Width fault seen since reset |
| setup_sticky_o | output | 1 | Setup fault seen since reset |
| hold_sticky_o | output | 1 | Hold fault seen since reset |
| width_count_o | output | VIOL_W | Saturating width fault count |
| setup_count_o | output | VIOL_W | Saturating setup fault count |
| hold_count_o | output | VIOL_W | Saturating hold fault count |

## Verification
The setup and hold checks can fire in the same cycle. This happens only when enable falls and data toggles in a single sample, because both checks then see zero elapsed time. The bench provokes this by driving both inputs at the same falling clock edge, with enable previously held high long enough that no width fault occurs. It then expects both pulses together in the next cycle. A saturation loop repeats the same pairing hundreds of times and expects both counts to stop at their maximum together.

// File: rtl/ltm_pkg.sv
package ltm_pkg;

  typedef enum int {
    V_WIDTH = 0,
    V_SETUP = 1,
    V_HOLD  = 2
  } viol_kind_e;

  localparam int NUM_VIOL = 3;

  // A threshold of zero can never be exceeded, so it disables the check.
  function automatic logic too_short(input logic [31:0] elapsed,
                                     input logic [31:0] limit);
    return elapsed < limit;
  endfunction

endpackage

// File: rtl/ltm_edge.sv
module ltm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic chg_o
);
  logic prev_q;
  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= sig_i;
      primed_q <= 1'b1;
    end
  end

  // The first sample only loads prev_q.
  assign chg_o = primed_q & (sig_i ^ prev_q);
endmodule

// File: rtl/ltm_elapsed.sv
module ltm_elapsed #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] elapsed_o
);
  localparam logic [W-1:0] MAX_V = '1;
  localparam logic [W-1:0] ONE_V = W'(1);

  // Starts saturated: no recent event at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed_o <= MAX_V;
    else if (restart_i)
      elapsed_o <= ONE_V;
    else if (elapsed_o != MAX_V)
      elapsed_o <= elapsed_o + ONE_V;
  end
endmodule

// File: rtl/ltm_viol_track.sv
module ltm_viol_track #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  output logic          pulse_o,
  output logic          sticky_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o  <= 1'b0;
      sticky_o <= 1'b0;
      count_o  <= '0;
    end else begin
      pulse_o <= hit_i;
      if (hit_i) begin
        sticky_o <= 1'b1;
        if (count_o != CMAX) count_o <= count_o + CONE;
      end
    end
  end
endmodule

// File: rtl/latch_timing_monitor.sv
module latch_timing_monitor
  import ltm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int VIOL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              din_i,
  input  logic [CNT_W-1:0]  width_min_i,
  input  logic [CNT_W-1:0]  setup_min_i,
  input  logic [CNT_W-1:0]  hold_min_i,
  output logic              width_viol_o,
  output logic              setup_viol_o,
  output logic              hold_viol_o,
  output logic              width_sticky_o,
  output logic              setup_sticky_o,
  output logic              hold_sticky_o,
  output logic [VIOL_W-1:0] width_count_o,
  output logic [VIOL_W-1:0] setup_count_o,
  output logic [VIOL_W-1:0] hold_count_o
);
  // Named internal events, also observed by the bound checker.
  logic             en_chg_w, din_chg_w, en_rise_w, en_fall_w;
  logic [CNT_W-1:0] since_en, since_din;
  logic [CNT_W-1:0] setup_elapsed, hold_elapsed;
  logic             seen_rise_q;
  logic [NUM_VIOL-1:0] hit;
  logic [NUM_VIOL-1:0] pulse_a, sticky_a;
  logic [VIOL_W-1:0]   count_a [NUM_VIOL];

  ltm_edge u_en_edge  (.clk(clk), .rst_n(rst_n), .sig_i(en_i),  .chg_o(en_chg_w));
  ltm_edge u_din_edge (.clk(clk), .rst_n(rst_n), .sig_i(din_i), .chg_o(din_chg_w));

  assign en_rise_w = en_chg_w &  en_i;
  assign en_fall_w = en_chg_w & ~en_i;

  ltm_elapsed #(.W(CNT_W)) u_since_en  (.clk(clk), .rst_n(rst_n),
                                        .restart_i(en_chg_w),  .elapsed_o(since_en));
  ltm_elapsed #(.W(CNT_W)) u_since_din (.clk(clk), .rst_n(rst_n),
                                        .restart_i(din_chg_w), .elapsed_o(since_din));

  // Tracks whether the pulse now ending began with a sampled rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_rise_q <= 1'b0;
    else if (en_rise_w)  seen_rise_q <= 1'b1;
    else if (en_fall_w)  seen_rise_q <= 1'b0;
  end

  // A simultaneous change means zero elapsed time.
  assign setup_elapsed = din_chg_w ? '0 : since_din;
  assign hold_elapsed  = en_chg_w  ? '0 : since_en;

  always_comb begin
    hit[V_WIDTH] = en_fall_w & seen_rise_q &
                   too_short(32'(since_en), 32'(width_min_i));
    hit[V_SETUP] = en_fall_w &
                   too_short(32'(setup_elapsed), 32'(setup_min_i));
    hit[V_HOLD]  = din_chg_w & ~en_i &
                   too_short(32'(hold_elapsed), 32'(hold_min_i));
  end

  for (genvar k = 0; k < NUM_VIOL; k++) begin : g_track
    ltm_viol_track #(.CW(VIOL_W)) u_track (
      .clk(clk), .rst_n(rst_n), .hit_i(hit[k]),
      .pulse_o(pulse_a[k]), .sticky_o(sticky_a[k]), .count_o(count_a[k])
    );
  end

  assign width_viol_o   = pulse_a[V_WIDTH];
  assign setup_viol_o   = pulse_a[V_SETUP];
  assign hold_viol_o    = pulse_a[V_HOLD];
  assign width_sticky_o = sticky_a[V_WIDTH];
  assign setup_sticky_o = sticky_a[V_SETUP];
  assign hold_sticky_o  = sticky_a[V_HOLD];
  assign width_count_o  = count_a[V_WIDTH];
  assign setup_count_o  = count_a[V_SETUP];
  assign hold_count_o   = count_a[V_HOLD];
endmodule

// File: rtl/ltm_checker.sv
module ltm_checker #(
  parameter int CNT_W  = 8,
  parameter int VIOL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [CNT_W-1:0]  width_min_i,
  input logic [CNT_W-1:0]  setup_min_i,
  input logic [CNT_W-1:0]  hold_min_i,
  input logic              en_fall_w,
  input logic              din_chg_w,
  input logic              width_viol_o,
  input logic              setup_viol_o,
  input logic              hold_viol_o,
  input logic              width_sticky_o,
  input logic              setup_sticky_o,
  input logic              hold_sticky_o,
  input logic [VIOL_W-1:0] width_count_o,
  input logic [VIOL_W-1:0] setup_count_o,
  input logic [VIOL_W-1:0] hold_count_o
);
  p_width_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    width_viol_o |-> $past(en_fall_w));

  p_setup_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_viol_o |-> $past(en_fall_w));

  p_hold_when_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_viol_o |-> $past(din_chg_w && !en_i));

  p_zero_width_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(width_min_i) == '0) |-> !width_viol_o);

  p_zero_setup_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(setup_min_i) == '0) |-> !setup_viol_o);

  p_zero_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_min_i) == '0) |-> !hold_viol_o);

  p_pulse_sets_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (width_viol_o |-> width_sticky_o) and (setup_viol_o |-> setup_sticky_o) and
    (hold_viol_o |-> hold_sticky_o));

  p_sticky_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(width_sticky_o) && !$fell(setup_sticky_o) && !$fell(hold_sticky_o));

  p_count_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (width_count_o >= $past(width_count_o)) && (setup_count_o >= $past(setup_count_o)) &&
    (hold_count_o >= $past(hold_count_o)));
endmodule

bind latch_timing_monitor ltm_checker #(.CNT_W(CNT_W), .VIOL_W(VIOL_W)) u_ltm_checker (
  .clk(clk), .rst_n(rst_n), .en_i(en_i),
  .width_min_i(width_min_i), .setup_min_i(setup_min_i), .hold_min_i(hold_min_i),
  .en_fall_w(en_fall_w), .din_chg_w(din_chg_w),
  .width_viol_o(width_viol_o), .setup_viol_o(setup_viol_o), .hold_viol_o(hold_viol_o),
  .width_sticky_o(width_sticky_o), .setup_sticky_o(setup_sticky_o),
  .hold_sticky_o(hold_sticky_o), .width_count_o(width_count_o),
  .setup_count_o(setup_count_o), .hold_count_o(hold_count_o)
);

// File: tb/latch_timing_monitor_bench.sv
module latch_timing_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int VW = 8;
  localparam int EMAX = (1 << CW) - 1;
  localparam int CMAX = (1 << VW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, din = 1'b1;
  logic [CW-1:0] wthr = '0, sthr = '0, hthr = '0;
  logic wv, sv, hv, ws, ss, hs;
  logic [VW-1:0] wc, sc, hc;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latch_timing_monitor #(.CNT_W(CW), .VIOL_W(VW)) u_latch_timing_monitor (
    .clk(clk), .rst_n(rst_n), .en_i(en), .din_i(din),
    .width_min_i(wthr), .setup_min_i(sthr), .hold_min_i(hthr),
    .width_viol_o(wv), .setup_viol_o(sv), .hold_viol_o(hv),
    .width_sticky_o(ws), .setup_sticky_o(ss), .hold_sticky_o(hs),
    .width_count_o(wc), .setup_count_o(sc), .hold_count_o(hc));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference, one update per sampled clock
  int  m_since_en, m_since_din, m_cnt [3];
  bit  m_en_prev, m_din_prev, m_primed, m_seen;
  bit  m_pulse [3], m_sticky [3];

  always @(posedge clk) begin
    bit ec, dc;
    bit h [3];
    if (!rst_n) begin
      m_since_en = EMAX; m_since_din = EMAX;
      m_primed = 0; m_seen = 0; m_en_prev = 0; m_din_prev = 0;
      for (int i = 0; i < 3; i++) begin m_pulse[i] = 0; m_sticky[i] = 0; m_cnt[i] = 0; end
    end else begin
      ec = m_primed && (en != m_en_prev);
      dc = m_primed && (din != m_din_prev);
      h[0] = ec && !en && m_seen && (m_since_en < int'(wthr));
      h[1] = ec && !en && ((dc ? 0 : m_since_din) < int'(sthr));
      h[2] = dc && !en && ((ec ? 0 : m_since_en) < int'(hthr));
      m_since_en  = ec ? 1 : ((m_since_en  < EMAX) ? m_since_en + 1  : EMAX);
      m_since_din = dc ? 1 : ((m_since_din < EMAX) ? m_since_din + 1 : EMAX);
      if (ec) m_seen = en;
      m_en_prev = en; m_din_prev = din; m_primed = 1;
      for (int i = 0; i < 3; i++) begin
        m_pulse[i] = h[i];
        if (h[i]) begin
          m_sticky[i] = 1;
          if (m_cnt[i] < CMAX) m_cnt[i]++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 width pulse",  int'(wv), int'(m_pulse[0]));
      chk("R4 setup pulse",  int'(sv), int'(m_pulse[1]));
      chk("R5 hold pulse",   int'(hv), int'(m_pulse[2]));
      chk("R9 width sticky", int'(ws), int'(m_sticky[0]));
      chk("R9 setup sticky", int'(ss), int'(m_sticky[1]));
      chk("R9 hold sticky",  int'(hs), int'(m_sticky[2]));
      chk("R10 width count", int'(wc), m_cnt[0]);
      chk("R10 setup count", int'(sc), m_cnt[1]);
      chk("R10 hold count",  int'(hc), m_cnt[2]);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: outputs held at zero in reset
    step(2);
    chk("R1 pulses in reset", int'({wv, sv, hv}), 0);
    chk("R1 sticky in reset", int'({ws, ss, hs}), 0);
    chk("R1 counts in reset", int'(wc) + int'(sc) + int'(hc), 0);
    wthr = 8'd20; sthr = 8'd20; hthr = 8'd5;
    rst_n = 1'b1;
    step(4);
    // R3: enable was high at the first sample, so this fall follows no rise
    en = 1'b0; step(1);
    chk("R3 no width on unseen rise", int'(wv), 0);
    chk("R3 width count", int'(wc), 0);
    // R2: 10-cycle pulse below threshold 20
    en = 1'b1; step(10); en = 1'b0; step(1);
    chk("R2 narrow pulse flagged", int'(wv), 1);
    chk("R2 width count", int'(wc), 1);
    // R2: 25-cycle pulse accepted
    en = 1'b1; step(25); en = 1'b0; step(1);
    chk("R2 wide pulse accepted", int'(wv), 0);
    // R4: data 5 cycles before the fall
    en = 1'b1; step(30); din = ~din; step(5); en = 1'b0; step(1);
    chk("R4 late data flagged", int'(sv), 1);
    chk("R4 no hold while high", int'(hv), 0);
    // R5: data 2 cycles after the fall
    step(1); din = ~din; step(1);
    chk("R5 early data flagged", int'(hv), 1);
    step(10); din = ~din; step(1);
    chk("R5 later data accepted", int'(hv), 0);
    chk("R5 hold count", int'(hc), 1);
    // R6: fall and data toggle in one sample
    en = 1'b1; step(30); en = 1'b0; din = ~din; step(1);
    chk("R6 setup on same cycle", int'(sv), 1);
    chk("R6 hold on same cycle", int'(hv), 1);
    // R7: all thresholds zero
    wthr = '0; sthr = '0; hthr = '0;
    en = 1'b1; step(2); en = 1'b0; din = ~din; step(1);
    chk("R7 no pulses", int'({wv, sv, hv}), 0);
    step(1); din = ~din; step(1);
    chk("R7 no hold pulse", int'(hv), 0);
    // R8: long quiet period, counter must saturate not wrap
    hthr = 8'd200; step(300); din = ~din; step(1);
    chk("R8 saturated elapsed, no hold", int'(hv), 0);
    // R10: many setup+hold pairs drive counts to saturation
    sthr = 8'd5;
    for (int i = 0; i < 300; i++) begin
      en = 1'b1; step(1); en = 1'b0; din = ~din; step(1);
    end
    step(1);
    chk("R10 setup count saturates", int'(sc), CMAX);
    chk("R10 hold count saturates", int'(hc), CMAX);
    chk("R10 width count unchanged", int'(wc), 1);
    // R9: flags persist, then clear on reset
    step(20);
    chk("R9 sticky persists", int'({ws, ss, hs}), 7);
    rst_n = 1'b0; step(2);
    chk("R9 sticky cleared by reset", int'({ws, ss, hs}), 0);
    chk("R1 counts cleared", int'(wc) + int'(sc) + int'(hc), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule